// File: doc/BRIEF.md
# Two-Port Shared Memory with Collision Arbitration

This block is a two-port synchronous memory. Two agents, called left and right, each get a full port with an active-low select, an active-low write strobe, an address, write data, registered read data and a pair of active-low busy pins. Both ports reach one shared storage array of `2**ADDR_W` words of `DATA_W` bits. The production configuration uses `ADDR_W = 13` and `DATA_W = 8`, which gives 8192 bytes. The parameter default is smaller so that the block elaborates quickly. All inputs are sampled on one shared clock, and the reset is synchronous and active high.

A port pair collides when both selects are low on the same address. The `master_sel` input decides how the busy pins are used:

- **Master role (`master_sel` high).** The block arbitrates the collision itself. It drives `*_busy_n_o` low, combinationally, to the port that loses. The loser's write is dropped, but its read still completes. Arbitration uses only select and address and never looks at the write strobe.
- **Slave role (`master_sel` low).** The block does not arbitrate and both busy outputs stay high. Each `*_busy_n_i` acts only as a write inhibit for its own port, sampled in the same edge that would commit the write. This lets several slave instances follow the busy decision of one master when memories are stacked for width.

Top module: `dpbsy_top`

## Requirements
- R1: A port with select low and write strobe low stores its write data at the clock edge, unless that port is inhibited. A port with select low loads `*_rdata` at the edge with the word held before any write of that same edge. With select high, `*_rdata` holds its value.
- R2: Accesses by the two ports to different addresses in the same cycle both complete, and neither busy output goes low.
- R3: A collision exists only when both selects are low and both addresses are equal. Without a collision both `*_busy_n_o` are high.
- R4: Arbitration ignores the write strobes. Two reads of the same address still leave one port busy.
- R5: When both ports begin accessing the same address in the same cycle, the left port wins and `r_busy_n_o` is low.
- R6: When a port was selected on an address in the previous cycle and the other port now arrives there, the newcomer is busy. The winner stays the same for as long as both ports stay on that address.
- R7: In the master role, a write from the busy port is dropped and the stored word is unchanged.
- R8: The busy port's read still returns the stored word.
- R9: In the slave role both `*_busy_n_o` are high. A port whose `*_busy_n_i` is low cannot write, and a port whose `*_busy_n_i` is high writes normally. In the master role `*_busy_n_i` has no effect.
- R10: In the slave role, when both ports write the same address in the same edge, the left port's data is stored.
- R11: Reset clears both `*_rdata` to zero and clears the arbitration history. It does not clear the array.
- R12: In the master role, `*_busy_n_o` follows the current selects and addresses in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous reset, active high |
| master_sel | input | 1 | 1 = master role (arbitrates), 0 = slave role (busy inputs inhibit writes) |
| l_cs_n | input | 1 | Left port select, active low |
| l_we_n | input | 1 | Left port write strobe, active low |
| l_addr | input | ADDR_W | Left port address |
| l_wdata | input | DATA_W | Left port write data |
| l_rdata | output | DATA_W | Left port registered read data |
| l_busy_n_i | input | 1 | Left port write inhibit in the slave role, active low |
| l_busy_n_o | output | 1 | Left port busy flag in the master role, active low |
| r_cs_n | input | 1 | Right port select, active low |
| r_we_n | input | 1 | Right port write strobe, active low |
| r_addr | input | ADDR_W | Right port address |
| r_wdata | input | DATA_W | Right port write data |
| r_rdata | output | DATA_W | Right port registered read data |
| r_busy_n_i | input | 1 | Right port write inhibit in the slave role, active low |
| r_busy_n_o | output | 1 | Right port busy flag in the master role, active low |

## Verification
The only internal state besides the array is the arbitration history: the previous select and address of each port and the held winner. A stale or wrong history shows at the busy outputs in the very cycle the second port arrives, or in the cycle after both ports stay on the address. A busy flag on the wrong side corrupts a word that becomes visible on the next read of that address. The bench therefore reads the array back after every group of writes. It also sweeps every address pair of a small configuration from a cleared history, so that each collision decision is seen directly.

// File: rtl/dpbsy_pkg.sv
package dpbsy_pkg;

    // Side of the memory; left has priority on a tie.
    typedef enum logic {
        SIDE_L = 1'b0,
        SIDE_R = 1'b1
    } side_e;

    // Decoded control of one port for the current cycle.
    typedef struct packed {
        logic act;   // select asserted
        logic wr;    // write strobe asserted
    } req_ctl_t;

    // Outcome of the collision check.
    typedef struct packed {
        logic  hit;      // both ports on the same word
        side_e winner;   // side that keeps the word
    } arb_res_t;

    localparam int unsigned NUM_SIDES = 2;

    // Choose the winner from who was already present on the address.
    function automatic side_e pick_winner(input logic here_l,
                                          input logic here_r,
                                          input side_e held);
        side_e w;
        if (here_l && here_r)
            w = held;
        else if (here_r)
            w = SIDE_R;
        else
            w = SIDE_L;
        return w;
    endfunction

endpackage

// File: rtl/dpbsy_port_front.sv
module dpbsy_port_front
    import dpbsy_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_sel,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy_n_i,
    input  logic              arb_busy,
    output req_ctl_t          ctl,
    output logic              wr_en,
    output logic              prev_act,
    output logic [ADDR_W-1:0] prev_addr
);

    logic inhibit;

    always_comb begin
        ctl.act = ~cs_n;
        ctl.wr  = ~we_n;
        // Master: own arbitration result; slave: external pin.
        inhibit = master_sel ? arb_busy : ~busy_n_i;
        wr_en   = ctl.act & ctl.wr & ~inhibit;
    end

    // One cycle of history so a later arrival can be told apart.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_act  <= 1'b0;
            prev_addr <= '0;
        end else begin
            prev_act  <= ctl.act;
            prev_addr <= addr;
        end
    end

endmodule

// File: rtl/dpbsy_arbiter.sv
module dpbsy_arbiter
    import dpbsy_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act       [NUM_SIDES],
    input  logic [ADDR_W-1:0] addr      [NUM_SIDES],
    input  logic              prev_act  [NUM_SIDES],
    input  logic [ADDR_W-1:0] prev_addr [NUM_SIDES],
    output logic              busy      [NUM_SIDES]
);

    arb_res_t res;
    side_e    held_q;
    logic     here [NUM_SIDES];

    generate
        for (genvar g = 0; g < NUM_SIDES; g++) begin : g_here
            assign here[g] = prev_act[g] && (prev_addr[g] == addr[g]);
        end
    endgenerate

    always_comb begin
        res.hit    = act[0] && act[1] && (addr[0] == addr[1]);
        res.winner = pick_winner(here[0], here[1], held_q);
        busy[0]    = res.hit && (res.winner == SIDE_R);
        busy[1]    = res.hit && (res.winner == SIDE_L);
    end

    always_ff @(posedge clk) begin
        if (rst)
            held_q <= SIDE_L;
        else if (res.hit)
            held_q <= res.winner;
    end

endmodule

// File: rtl/dpbsy_mem.sv
module dpbsy_mem
    import dpbsy_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en [NUM_SIDES],
    input  logic              wr_en [NUM_SIDES],
    input  logic [ADDR_W-1:0] addr  [NUM_SIDES],
    input  logic [DATA_W-1:0] wdata [NUM_SIDES],
    output logic [DATA_W-1:0] rdata [NUM_SIDES]
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Right first, left last: left data lands on a shared word.
    always_ff @(posedge clk) begin
        for (int g = NUM_SIDES - 1; g >= 0; g--) begin
            if (wr_en[g])
                store[addr[g]] <= wdata[g];
        end
    end

    generate
        for (genvar g = 0; g < NUM_SIDES; g++) begin : g_rd
            always_ff @(posedge clk) begin
                if (rst)
                    rdata[g] <= '0;
                else if (rd_en[g])
                    rdata[g] <= store[addr[g]];
            end
        end
    endgenerate

endmodule

// File: rtl/dpbsy_top.sv
module dpbsy_top
    import dpbsy_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_sel,
    input  logic              l_cs_n,
    input  logic              l_we_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              l_busy_n_i,
    output logic              l_busy_n_o,
    input  logic              r_cs_n,
    input  logic              r_we_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    input  logic              r_busy_n_i,
    output logic              r_busy_n_o
);

    logic              cs_n_v    [NUM_SIDES];
    logic              we_n_v    [NUM_SIDES];
    logic [ADDR_W-1:0] addr_v    [NUM_SIDES];
    logic [DATA_W-1:0] wdata_v   [NUM_SIDES];
    logic [DATA_W-1:0] rdata_v   [NUM_SIDES];
    logic              bin_v     [NUM_SIDES];
    req_ctl_t          ctl_v     [NUM_SIDES];
    logic              act_v     [NUM_SIDES];
    logic              wr_en_v   [NUM_SIDES];
    logic              pact_v    [NUM_SIDES];
    logic [ADDR_W-1:0] paddr_v   [NUM_SIDES];
    logic              busy_v    [NUM_SIDES];

    always_comb begin
        cs_n_v[0]  = l_cs_n;     cs_n_v[1]  = r_cs_n;
        we_n_v[0]  = l_we_n;     we_n_v[1]  = r_we_n;
        addr_v[0]  = l_addr;     addr_v[1]  = r_addr;
        wdata_v[0] = l_wdata;    wdata_v[1] = r_wdata;
        bin_v[0]   = l_busy_n_i; bin_v[1]   = r_busy_n_i;
    end

    generate
        for (genvar g = 0; g < NUM_SIDES; g++) begin : g_port
            dpbsy_port_front #(.ADDR_W(ADDR_W)) u_front (
                .clk        (clk),
                .rst        (rst),
                .master_sel (master_sel),
                .cs_n       (cs_n_v[g]),
                .we_n       (we_n_v[g]),
                .addr       (addr_v[g]),
                .busy_n_i   (bin_v[g]),
                .arb_busy   (busy_v[g]),
                .ctl        (ctl_v[g]),
                .wr_en      (wr_en_v[g]),
                .prev_act   (pact_v[g]),
                .prev_addr  (paddr_v[g])
            );
            assign act_v[g] = ctl_v[g].act;
        end
    endgenerate

    dpbsy_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .act       (act_v),
        .addr      (addr_v),
        .prev_act  (pact_v),
        .prev_addr (paddr_v),
        .busy      (busy_v)
    );

    dpbsy_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .rd_en (act_v),
        .wr_en (wr_en_v),
        .addr  (addr_v),
        .wdata (wdata_v),
        .rdata (rdata_v)
    );

    always_comb begin
        l_rdata    = rdata_v[0];
        r_rdata    = rdata_v[1];
        l_busy_n_o = master_sel ? ~busy_v[0] : 1'b1;
        r_busy_n_o = master_sel ? ~busy_v[1] : 1'b1;
    end

endmodule

// File: rtl/dpbsy_chk.sv
module dpbsy_chk #(
    parameter int unsigned ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              master_sel,
    input logic              l_cs_n,
    input logic              r_cs_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_busy_n_o,
    input logic              r_busy_n_o
);

    logic seen;
    logic match;

    assign match = !l_cs_n && !r_cs_n && (l_addr == r_addr);

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    // R3: no shared word, no busy flag
    p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !match |-> (l_busy_n_o && r_busy_n_o));

    // R4: a collision in the master role leaves exactly one loser
    p_one_loser_r4: assert property (@(posedge clk) disable iff (rst)
        (master_sel && match) |-> ($countones({l_busy_n_o, r_busy_n_o}) == 1));

    // R9: slave role never drives busy low
    p_slave_high_r9: assert property (@(posedge clk) disable iff (rst)
        !master_sel |-> (l_busy_n_o && r_busy_n_o));

    // R5: both arrive together, left keeps the word
    p_tie_left_r5: assert property (@(posedge clk) disable iff (rst)
        (seen && master_sel && match && $past(l_cs_n) && $past(r_cs_n))
        |-> (l_busy_n_o && !r_busy_n_o));

    // R6: winner holds while both stay on the word
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (seen && master_sel && $past(master_sel) && match && $past(match)
         && $stable(l_addr) && $stable(r_addr))
        |-> ($stable(l_busy_n_o) && $stable(r_busy_n_o)));

endmodule

bind dpbsy_top dpbsy_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_dpbsy_top.sv
module sim_dpbsy_top;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          master_sel;
    logic          l_cs_n, l_we_n, l_busy_n_i, l_busy_n_o;
    logic          r_cs_n, r_we_n, r_busy_n_i, r_busy_n_o;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    dpbsy_top #(.ADDR_W(AW), .DATA_W(DW)) u0 (.*);

    function automatic logic [DW-1:0] pat(input int a, input int k);
        return DW'((a * 37 + k * 11 + 5) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        l_cs_n = 1; l_we_n = 1; r_cs_n = 1; r_we_n = 1;
        l_busy_n_i = 1; r_busy_n_i = 1;
    endtask

    task automatic rd_r(input int a, input logic [DW-1:0] exp, input string req);
        idle(); r_cs_n = 0; r_addr = AW'(a);
        tick();
        chk(r_rdata == exp, req, r_rdata, exp);
    endtask

    task automatic rd_l(input int a, input logic [DW-1:0] exp, input string req);
        idle(); l_cs_n = 0; l_addr = AW'(a);
        tick();
        chk(l_rdata == exp, req, l_rdata, exp);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        l_addr = 0; r_addr = 0; l_wdata = 0; r_wdata = 0;
        master_sel = 1; rst = 1;
        repeat (3) tick();
        // R11: reset state
        chk(l_rdata == 0 && r_rdata == 0, "R11 rdata", {l_rdata, r_rdata}, 0);
        chk(l_busy_n_o && r_busy_n_o, "R11 busy", {l_busy_n_o, r_busy_n_o}, 3);
        rst = 0;

        // R1 (and R9: busy_n_i low has no effect in master role)
        for (int a = 0; a < NW; a++) begin
            idle(); l_busy_n_i = 0;
            l_cs_n = 0; l_we_n = 0; l_addr = AW'(a); l_wdata = pat(a, 0);
            tick();
        end
        for (int a = 0; a < NW; a++) rd_r(a, pat(a, 0), "R1 R9 right readback");
        for (int a = 0; a < NW; a++) rd_l(a, pat(a, 0), "R1 left readback");

        // R1: read-first on a same-edge write
        idle(); l_cs_n = 0; l_we_n = 0; l_addr = 3; l_wdata = 8'hC3;
        tick();
        chk(l_rdata == pat(3, 0), "R1 read-first", l_rdata, pat(3, 0));
        rd_l(3, 8'hC3, "R1 written");
        // R1: rdata holds when deselected
        idle(); tick();
        chk(l_rdata == 8'hC3, "R1 hold", l_rdata, 8'hC3);

        // R2: parallel writes to distinct words
        for (int a = 0; a < NW / 2; a++) begin
            idle();
            l_cs_n = 0; l_we_n = 0; l_addr = AW'(a);          l_wdata = pat(a, 1);
            r_cs_n = 0; r_we_n = 0; r_addr = AW'(a + NW / 2); r_wdata = pat(a + NW / 2, 1);
            #1;
            chk(l_busy_n_o && r_busy_n_o, "R2 no busy", {l_busy_n_o, r_busy_n_o}, 3);
            tick();
        end
        for (int a = 0; a < NW; a++) rd_l(a, pat(a, 1), "R2 readback");

        // R3 R4 R5 R12: every address pair from a cleared history, both reading
        for (int la = 0; la < NW; la++) begin
            for (int ra = 0; ra < NW; ra++) begin
                idle(); tick();
                l_cs_n = 0; l_addr = AW'(la);
                r_cs_n = 0; r_addr = AW'(ra);
                #1;
                chk(l_busy_n_o == 1'b1, "R3 R5 R12 left busy", l_busy_n_o, 1);
                chk(r_busy_n_o == (la != ra), "R3 R4 R5 R12 right busy",
                    r_busy_n_o, (la != ra));
            end
        end
        // R3: one side deselected on the same address
        idle(); tick();
        l_cs_n = 0; l_addr = 5; r_addr = 5; #1;
        chk(l_busy_n_o && r_busy_n_o, "R3 single select", {l_busy_n_o, r_busy_n_o}, 3);

        // R6: left first, then right arrives
        idle(); tick();
        l_cs_n = 0; l_addr = 3; tick();
        r_cs_n = 0; r_addr = 3; #1;
        chk(l_busy_n_o && !r_busy_n_o, "R6 left first", {l_busy_n_o, r_busy_n_o}, 2);
        tick(); tick();
        chk(l_busy_n_o && !r_busy_n_o, "R6 held", {l_busy_n_o, r_busy_n_o}, 2);
        // R6: right first, then left arrives
        idle(); tick();
        r_cs_n = 0; r_addr = 3; tick();
        l_cs_n = 0; l_addr = 3; #1;
        chk(!l_busy_n_o && r_busy_n_o, "R6 right first", {l_busy_n_o, r_busy_n_o}, 1);
        tick();
        chk(!l_busy_n_o && r_busy_n_o, "R6 held right", {l_busy_n_o, r_busy_n_o}, 1);

        // R7: right holds word 6, left writes it while busy
        idle(); tick();
        r_cs_n = 0; r_addr = 6; tick();
        l_cs_n = 0; l_we_n = 0; l_addr = 6; l_wdata = 8'hA5; #1;
        chk(!l_busy_n_o, "R7 left busy", l_busy_n_o, 0);
        tick();
        rd_r(6, pat(6, 1), "R7 word unchanged");

        // R8: left holds word 9, right writes it while busy; its read still works
        idle(); tick();
        l_cs_n = 0; l_addr = 9; tick();
        r_cs_n = 0; r_we_n = 0; r_addr = 9; r_wdata = 8'h5A; #1;
        chk(!r_busy_n_o, "R8 right busy", r_busy_n_o, 0);
        tick();
        chk(r_rdata == pat(9, 1), "R8 busy read", r_rdata, pat(9, 1));
        rd_l(9, pat(9, 1), "R7 word unchanged right");

        // R9: slave role
        master_sel = 0;
        idle(); l_cs_n = 0; l_we_n = 0; l_addr = 2; l_wdata = 8'h11; l_busy_n_i = 0;
        r_cs_n = 0; r_addr = 2; #1;
        chk(l_busy_n_o && r_busy_n_o, "R9 slave busy high", {l_busy_n_o, r_busy_n_o}, 3);
        tick();
        rd_r(2, pat(2, 1), "R9 inhibited left");
        idle(); l_cs_n = 0; l_we_n = 0; l_addr = 2; l_wdata = 8'h22; tick();
        rd_r(2, 8'h22, "R9 allowed left");
        idle(); r_cs_n = 0; r_we_n = 0; r_addr = 4; r_wdata = 8'h44; r_busy_n_i = 0; tick();
        rd_l(4, pat(4, 1), "R9 inhibited right");

        // R10: both write one word in slave role
        idle();
        l_cs_n = 0; l_we_n = 0; l_addr = 7; l_wdata = 8'h77;
        r_cs_n = 0; r_we_n = 0; r_addr = 7; r_wdata = 8'h88;
        tick();
        rd_r(7, 8'h77, "R10 left data kept");

        // R11: reset clears rdata, not the array
        idle(); rst = 1; tick(); rst = 0;
        chk(l_rdata == 0 && r_rdata == 0, "R11 rdata cleared", {l_rdata, r_rdata}, 0);
        rd_l(7, 8'h77, "R11 array kept");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule